// File: doc/BRIEF.md
# Flash Bus Write Qualifier

This block sits between the sampled control pins of a flash memory array and its command state machine. It watches three active-low controls: chip select, write strobe and read strobe. It decides when they form a real bus write to the command register. When a write is qualified, the block emits a one-cycle accept pulse. The command logic uses that pulse to capture the address and data that are present on the bus when the write strobe returns high.

Three guards stand in front of the accept pulse. The first is a width filter: the write form has to be held without a break for a set number of sampling-clock cycles. The second is a supply guard: while the low-supply flag is set, every write is refused and the command logic is held in reset. The third is a start-up guard: if a write is already being driven when power-on reset releases, or when the supply recovers, that write is discarded. The controls must first leave the write form before any new write can count.

Top module: `flash_wr_qual`

## Requirements
- R1: While `rst_n` is low, `wr_accept` is 0 and `sm_rst` is 1.
- R2: The write form is `cs_n`=0, `we_n`=0 and `oe_n`=1. If it is held for at least GLITCH_CYC consecutive sampled cycles and `we_n` then rises while `cs_n`=0 and `oe_n`=1, `wr_accept` is 1 for the cycle that follows the first clock edge that samples `we_n`=1.
- R3: `oe_n`=0 inhibits writes. A low write strobe with `oe_n` low never produces `wr_accept`.
- R4: `cs_n`=1 inhibits writes. A write strobe pulse with chip select high gives no accept. A cycle in which `cs_n` rises before `we_n` also gives no accept.
- R5: A write form that lasts GLITCH_CYC-1 sampled cycles is rejected. One that lasts exactly GLITCH_CYC cycles is accepted.
- R6: The qualifying interval must be unbroken. Any sampled cycle outside the write form restarts the count from zero.
- R7: While `vlow`=1, no write is accepted. `sm_rst` goes to 1 one clock edge after `vlow` is first sampled high, and returns to 0 one edge after `vlow` is sampled low.
- R8: If the write form is present when `rst_n` releases, the next rise of `we_n` is not accepted. A later, separate write is accepted.
- R9: A write form that spans a period of `vlow`=1 is not accepted when `we_n` rises after the supply has recovered.
- R10: `wr_accept` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n | input | 1 | Sampled chip select, active low |
| we_n | input | 1 | Sampled write strobe, active low |
| oe_n | input | 1 | Sampled read strobe, active low |
| vlow | input | 1 | Supply below the lockout level, active high |
| wr_accept | output | 1 | One-cycle pulse that qualifies a command write and strobes the address and data latch |
| sm_rst | output | 1 | Reset to the command state machine, which returns it to array read |

## Verification
Write strobe pulses are driven at GLITCH_CYC-1, GLITCH_CYC and longer widths. This separates the filter threshold from an off-by-one error. An unbroken low strobe is compared with one that a one-cycle read-strobe dip interrupts, which shows that the count restarts instead of pausing. The write form is removed one control at a time: read strobe low, chip select high, and chip select rising before the write strobe. Each of these must give no accept, so each inhibit term is tested on its own. The start-up case holds the write form across the reset release and across a low-supply episode. It then follows each with a clean write, which tells a discarded stale write apart from a block that stays locked.

// File: rtl/flash_wr_qual.sv
module flash_wr_qual #(
  parameter int GLITCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic vlow,
  output logic wr_accept,
  output logic sm_rst
);
  localparam int CW = $clog2(GLITCH_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(GLITCH_CYC);

  logic [CW-1:0] run_cnt;
  logic          stale;
  logic          wr_form;
  logic          we_rise_ok;

  assign wr_form    = !cs_n && !we_n && oe_n;
  assign we_rise_ok = we_n && !cs_n && oe_n && !vlow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stale <= 1'b1;
    end else begin
      stale <= vlow || (stale && wr_form);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (vlow || stale || !wr_form) begin
      run_cnt <= '0;
    end else if (run_cnt != FULL) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_accept <= 1'b0;
      sm_rst    <= 1'b1;
    end else begin
      wr_accept <= (run_cnt == FULL) && we_rise_ok && !stale;
      sm_rst    <= vlow;
    end
  end
endmodule

module flash_wr_qual_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic we_n,
  input logic oe_n,
  input logic vlow,
  input logic wr_accept,
  input logic sm_rst
);
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !wr_accept);

  assert_we_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> ($past(we_n) && !$past(we_n, 2)));

  assert_oe_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> ($past(oe_n) && $past(oe_n, 2)));

  assert_cs_inhibit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> (!$past(cs_n) && !$past(cs_n, 2)));

  assert_low_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vlow |=> (sm_rst && !wr_accept));

  assert_supply_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vlow |=> !sm_rst);
endmodule

bind flash_wr_qual flash_wr_qual_chk u_chk (.*);

// File: tb/flash_wr_qual_tb.sv
module flash_wr_qual_tb;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vlow = 1'b0;
  logic wr_accept, sm_rst;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_wr_qual #(.GLITCH_CYC(G)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .vlow(vlow), .wr_accept(wr_accept), .sm_rst(sm_rst));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int len, input logic exp, input string req);
    cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    repeat (len) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    check(req, wr_accept, exp);
    @(negedge clk);
    check("R10", wr_accept, 1'b0);
    idle(2);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    check("R1 accept", wr_accept, 1'b0);
    check("R1 smrst", sm_rst, 1'b1);
    rst_n = 1'b1;
    idle(2);
    check("R7 smrst idle", sm_rst, 1'b0);
  endtask

  task automatic t_basic();
    pulse(G, 1'b1, "R2 exact");
    pulse(G + 3, 1'b1, "R2 long");
    pulse(G - 1, 1'b0, "R5 short");
    pulse(1, 1'b0, "R5 one");
    pulse(G, 1'b1, "R5 exact");
  endtask

  task automatic t_inhibit();
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    repeat (G + 2) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); check("R3", wr_accept, 1'b0);
    @(negedge clk); check("R3", wr_accept, 1'b0);
    idle(2);
    cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b0;
    repeat (G + 2) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); check("R4 cs high", wr_accept, 1'b0);
    idle(2);
    cs_n = 1'b0; we_n = 1'b0;
    repeat (G + 2) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); check("R4 cs first", wr_accept, 1'b0);
    @(negedge clk); check("R4 cs first", wr_accept, 1'b0);
    idle(2);
  endtask

  task automatic t_break();
    cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    repeat (2) @(negedge clk);
    oe_n = 1'b0;
    @(negedge clk);
    oe_n = 1'b1;
    repeat (G - 1) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); check("R6 restart", wr_accept, 1'b0);
    idle(2);
  endtask

  task automatic t_supply();
    vlow = 1'b1;
    @(negedge clk);
    check("R7 smrst on", sm_rst, 1'b1);
    pulse(G + 2, 1'b0, "R7 blocked");
    check("R7 smrst held", sm_rst, 1'b1);
    vlow = 1'b0;
    @(negedge clk);
    check("R7 smrst off", sm_rst, 1'b0);
    pulse(G, 1'b1, "R7 recovered");
    cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    repeat (2) @(negedge clk);
    vlow = 1'b1;
    repeat (2) @(negedge clk);
    vlow = 1'b0;
    repeat (G + 2) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); check("R9 stale", wr_accept, 1'b0);
    idle(2);
    pulse(G, 1'b1, "R9 fresh");
  endtask

  task automatic t_powerup();
    rst_n = 1'b0;
    cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (G + 3) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); check("R8 stale", wr_accept, 1'b0);
    @(negedge clk); check("R8 stale", wr_accept, 1'b0);
    idle(2);
    pulse(G, 1'b1, "R8 fresh");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_inhibit();
    t_break();
    t_supply();
    t_powerup();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule